// File: doc/BRIEF.md
# Wormhole Many-to-One Output Switch

This block merges several input flit streams onto a single shared output link and keeps every packet whole on that link. A packet is a head flit, any number of body flits and a tail flit. A flit that is both head and tail forms a one-flit packet. Only head flits compete for the link. The winner owns the link until its tail flit has crossed, and flits from other inputs cannot interleave with it.

The switch holds a free bit for the link and a one-hot owner vector with one bit per input. A head flit may only request when the link is free and the receiver reports buffer space. A round-robin arbiter picks one request. Its one-hot grant steers the output multiplexer and loads the owner vector. While the link is owned, the owner's flits pass whenever the owner is valid and the receiver is ready. Each transferred flit pops one entry from its input through a per-input pop strobe. The transfer path is combinational, so a flit crosses in the cycle it is offered. Buffering on either side belongs to the neighbouring blocks.

Top module: `wh_out_switch`

## Requirements
- R1: The flit kind is two bits: bit 0 marks a head and bit 1 marks a tail, so body=00, head=01, tail=10 and a one-flit packet=11. Each transferred flit appears on `out_data`/`out_kind` unchanged, and each input's flits appear in the order that input offered them.
- R2: When a head flit that is not a tail is transferred from a free link, `link_free` is 0 and `link_owner` equals the winning input's one-hot bit from the next cycle on.
- R3: `link_free` is 1 exactly when `link_owner` is all zeros. Otherwise `link_owner` has exactly one bit set.
- R4: While the link is owned, only the owner's flits are transferred. Head flits on other inputs do not request and do not move.
- R5: The arbiter is round-robin. The search starts at a pointer that is 0 after reset. After a head transfer from a free link, the pointer becomes the input after the winner (wrapping from N_IN-1 to 0). Nothing else moves the pointer.
- R6: No flit is transferred while `out_ready` is 0, so `out_valid` implies `out_ready`.
- R7: `in_pop` is one-hot with the transferring input's bit in every cycle where `out_valid` is 1, and all zeros otherwise.
- R8: Transferring a tail flit on an owned link sets `link_free` and clears `link_owner` in the next cycle.
- R9: A one-flit packet (kind 11) leaves the link free and the owner vector zero after it crosses.
- R10: While `rst_n` is low, `out_valid` and `in_pop` are 0. After reset, `link_free` is 1 and `link_owner` is 0.
- R11: If the owner stops offering flits in the middle of a packet, the link stays owned by that input and nothing is transferred until it resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N_IN | Per-input flit present |
| in_kind | input | 2*N_IN | Per-input flit kind, input i at bits [2i+1:2i] |
| in_data | input | DATA_W*N_IN | Per-input flit payload, input i at bits [DATA_W*i +: DATA_W] |
| in_pop | output | N_IN | Per-input strobe: the offered flit was taken this cycle |
| out_valid | output | 1 | A flit crosses the link this cycle |
| out_kind | output | 2 | Kind of the crossing flit |
| out_data | output | DATA_W | Payload of the crossing flit |
| out_ready | input | 1 | Receiver has at least one free slot |
| link_free | output | 1 | Link is free for a new packet |
| link_owner | output | N_IN | One-hot input that owns the link, zero when free |

## Verification
Every cycle, the assertions check the consistency between the free bit and the owner vector. They also check that the link is taken after a multi-flit head and released after a tail or a one-flit packet. They check that ownership holds through stalls, that only the owner pops while the link is taken, and that nothing crosses without ready. The round-robin order, the path of payloads and kinds from input to output, and the ordering of whole packets among competing inputs only show up in the bench scenarios. Those scenarios are preloaded contention, back-pressure patterns and a mid-packet stall with another head waiting, and the scoreboard compares every crossing flit against the expected sequence.

// File: rtl/wh_sw_pkg.sv
// Package: shared flit-kind encoding for the wormhole output switch.
// Assumes two kind bits per flit: bit 0 = head, bit 1 = tail.
package wh_sw_pkg;

    typedef enum logic [1:0] {
        FK_BODY = 2'b00,
        FK_HEAD = 2'b01,
        FK_TAIL = 2'b10,
        FK_SOLO = 2'b11
    } flit_kind_e;

    // Head marker of a kind code
    function automatic logic kind_is_head(input logic [1:0] k);
        return k[0];
    endfunction

    // Tail marker of a kind code
    function automatic logic kind_is_tail(input logic [1:0] k);
        return k[1];
    endfunction

endpackage

// File: rtl/wh_req_gate.sv
// Module: wh_req_gate
// Forms arbitration requests: an input requests only when it offers a
// head flit, the link is free and the receiver has space.
// Assumes in_kind packs two bits per input, input i at [2i+1:2i].
module wh_req_gate #(
    parameter int N_IN = 4
) (
    input  logic [N_IN-1:0]   in_valid,
    input  logic [2*N_IN-1:0] in_kind,
    input  logic              link_free,
    input  logic              out_ready,
    output logic [N_IN-1:0]   req
);
    import wh_sw_pkg::*;

    generate
        for (genvar g = 0; g < N_IN; g++) begin : g_req
            // Qualify one input's head valid with link state and ready
            always_comb begin
                req[g] = in_valid[g] & kind_is_head(in_kind[2*g +: 2])
                         & link_free & out_ready;
            end
        end
    endgenerate

endmodule

// File: rtl/wh_rr_arbiter.sv
// Module: wh_rr_arbiter
// Round-robin arbiter with a one-hot grant. The search starts at a priority
// pointer. The pointer moves past the winner only when 'advance' is high.
// Assumes advance is asserted only in a cycle with a nonzero grant.
module wh_rr_arbiter #(
    parameter int N_IN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] req,
    input  logic            advance,
    output logic [N_IN-1:0] grant
);
    localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] win_idx;
    logic          found;

    // Scan requests from the pointer with wrap-around, first one wins
    always_comb begin
        grant   = '0;
        win_idx = '0;
        found   = 1'b0;
        for (int off = 0; off < N_IN; off++) begin
            int cand;
            cand = int'(ptr_q) + off;
            if (cand >= N_IN) cand = cand - N_IN;
            if (!found && req[cand]) begin
                found       = 1'b1;
                grant[cand] = 1'b1;
                win_idx     = IW'(cand);
            end
        end
    end

    // Move the priority pointer to the input after the winner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance && found) begin
            if (int'(win_idx) == N_IN - 1) ptr_q <= '0;
            else                           ptr_q <= win_idx + 1'b1;
        end
    end

endmodule

// File: rtl/wh_flit_mux.sv
// Module: wh_flit_mux
// AND-OR multiplexer that drives the selected input's flit onto the link.
// Assumes sel is one-hot or zero; a zero select yields zero outputs.
module wh_flit_mux #(
    parameter int N_IN   = 4,
    parameter int DATA_W = 32
) (
    input  logic [N_IN-1:0]        sel,
    input  logic [N_IN-1:0]        in_valid,
    input  logic [2*N_IN-1:0]      in_kind,
    input  logic [DATA_W*N_IN-1:0] in_data,
    output logic                   src_valid,
    output logic [1:0]             src_kind,
    output logic [DATA_W-1:0]      src_data
);
    // Merge the selected lane into one flit
    always_comb begin
        src_valid = 1'b0;
        src_kind  = '0;
        src_data  = '0;
        for (int i = 0; i < N_IN; i++) begin
            src_valid = src_valid | (sel[i] & in_valid[i]);
            src_kind  = src_kind  | (in_kind[2*i +: 2] & {2{sel[i]}});
            src_data  = src_data  | (in_data[DATA_W*i +: DATA_W] & {DATA_W{sel[i]}});
        end
    end

endmodule

// File: rtl/wh_lock_ctrl.sv
// Module: wh_lock_ctrl
// Holds the link-free bit and the one-hot owner vector. A multi-flit head
// taken from a free link loads the owner; a tail on an owned link frees it.
// Assumes fire marks a transfer and grant is one-hot when fire and free.
module wh_lock_ctrl #(
    parameter int N_IN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic            flit_tail,
    input  logic [N_IN-1:0] grant,
    output logic            link_free,
    output logic [N_IN-1:0] link_owner
);
    // Update ownership on head and tail transfers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_free  <= 1'b1;
            link_owner <= '0;
        end else if (fire) begin
            if (link_free) begin
                if (!flit_tail) begin
                    link_free  <= 1'b0;
                    link_owner <= grant;
                end
            end else if (flit_tail) begin
                link_free  <= 1'b1;
                link_owner <= '0;
            end
        end
    end

endmodule

// File: rtl/wh_out_switch.sv
// Module: wh_out_switch (top)
// Many-to-one wormhole switch: arbitrates head flits round-robin, holds the
// link for the winner until its tail, and forwards flits combinationally.
// Assumes inputs hold a flit stable until its pop strobe, and that the
// receiver takes a flit in every cycle where out_valid is high.
module wh_out_switch #(
    parameter int N_IN   = 4,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        in_valid,
    input  logic [2*N_IN-1:0]      in_kind,
    input  logic [DATA_W*N_IN-1:0] in_data,
    output logic [N_IN-1:0]        in_pop,
    output logic                   out_valid,
    output logic [1:0]             out_kind,
    output logic [DATA_W-1:0]      out_data,
    input  logic                   out_ready,
    output logic                   link_free,
    output logic [N_IN-1:0]        link_owner
);
    import wh_sw_pkg::*;

    logic [N_IN-1:0]   req;
    logic [N_IN-1:0]   grant;
    logic [N_IN-1:0]   sel;
    logic              src_valid;
    logic [1:0]        src_kind;
    logic [DATA_W-1:0] src_data;
    logic              fire;

    wh_req_gate #(.N_IN(N_IN)) u_gate (
        .in_valid  (in_valid),
        .in_kind   (in_kind),
        .link_free (link_free),
        .out_ready (out_ready),
        .req       (req)
    );

    wh_rr_arbiter #(.N_IN(N_IN)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .advance (fire & link_free),
        .grant   (grant)
    );

    // Select the arbiter winner when free, the owner when locked
    always_comb begin
        sel = link_free ? grant : link_owner;
    end

    wh_flit_mux #(.N_IN(N_IN), .DATA_W(DATA_W)) u_mux (
        .sel       (sel),
        .in_valid  (in_valid),
        .in_kind   (in_kind),
        .in_data   (in_data),
        .src_valid (src_valid),
        .src_kind  (src_kind),
        .src_data  (src_data)
    );

    // A transfer needs a valid selected flit, receiver space and no reset
    always_comb begin
        fire      = src_valid & out_ready & rst_n;
        out_valid = fire;
        out_kind  = src_kind;
        out_data  = src_data;
        in_pop    = sel & {N_IN{fire}};
    end

    wh_lock_ctrl #(.N_IN(N_IN)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .flit_tail  (kind_is_tail(src_kind)),
        .grant      (grant),
        .link_free  (link_free),
        .link_owner (link_owner)
    );

endmodule

// Checker: port-level properties of the wormhole switch.
module wh_out_switch_chk #(
    parameter int N_IN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_IN-1:0] in_pop,
    input logic            out_valid,
    input logic [1:0]      out_kind,
    input logic            out_ready,
    input logic            link_free,
    input logic [N_IN-1:0] link_owner
);
    // R3: free bit and owner vector agree
    a_r3_free_no_owner: assert property (@(posedge clk) disable iff (!rst_n)
        link_free |-> (link_owner == '0));
    a_r3_owned_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        !link_free |-> $onehot(link_owner));

    // R2: a multi-flit head from a free link takes the link for its input
    a_r2_head_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && link_free && !out_kind[1]) |=>
            (!link_free && link_owner == $past(in_pop)));

    // R4: while owned, only the owner pops
    a_r4_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !link_free) |-> (in_pop == link_owner));

    // R6: no transfer without receiver space
    a_r6_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_ready);

    // R7: pop strobe is one-hot with a transfer, idle otherwise
    a_r7_pop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot(in_pop));
    a_r7_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (in_pop == '0));

    // R8: a tail on an owned link frees it
    a_r8_tail_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !link_free && out_kind[1]) |=>
            (link_free && link_owner == '0));

    // R9: a one-flit packet leaves the link free
    a_r9_solo_free: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && link_free && out_kind == 2'b11) |=>
            (link_free && link_owner == '0));

    // R11: ownership holds through a stall
    a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_free && !out_valid) |=> (!link_free && $stable(link_owner)));

    // R10: nothing crosses during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r10_quiet_reset: assert (!out_valid && in_pop == '0);
        end
    end

endmodule

bind wh_out_switch wh_out_switch_chk #(.N_IN(N_IN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_pop     (in_pop),
    .out_valid  (out_valid),
    .out_kind   (out_kind),
    .out_ready  (out_ready),
    .link_free  (link_free),
    .link_owner (link_owner)
);

// File: tb/wh_out_switch_test.sv
// Bench: per-input flit sources, a scoreboard of expected crossings and a
// monitor that compares every flit leaving the link.
module wh_out_switch_test;
    localparam int NI = 4;
    localparam int DW = 16;

    typedef struct packed {
        logic [1:0]    kind;
        logic [DW-1:0] data;
        logic [7:0]    gap;
    } sflit_t;

    typedef struct packed {
        logic [7:0]    src;
        logic [1:0]    kind;
        logic [DW-1:0] data;
    } exp_t;

    logic              clk;
    logic              rst_n;
    logic [NI-1:0]     in_valid;
    logic [2*NI-1:0]   in_kind;
    logic [DW*NI-1:0]  in_data;
    logic [NI-1:0]     in_pop;
    logic              out_valid;
    logic [1:0]        out_kind;
    logic [DW-1:0]     out_data;
    logic              out_ready;
    logic              link_free;
    logic [NI-1:0]     link_owner;

    sflit_t srcq[NI][$];
    sflit_t shadow[NI][$];
    exp_t   expq[$];
    logic [NI-1:0] pop_seen;
    logic [NI-1:0] armed;
    int     wait_c[NI];
    int     n_checks;
    int     n_errs;
    int     seq;
    bit     ready_mode;
    int     cyc;

    wh_out_switch #(.N_IN(NI), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_data(in_data), .in_pop(in_pop), .out_valid(out_valid),
        .out_kind(out_kind), .out_data(out_data), .out_ready(out_ready),
        .link_free(link_free), .link_owner(link_owner)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: queue a packet at a source; tail_gap idles before the tail
    task automatic send_packet(input int src, input int nbody, input bit solo,
                               input int tail_gap);
        sflit_t f;
        f.gap = '0;
        if (solo) begin
            f.kind = 2'b11; f.data = DW'((src << 12) | (seq & 12'hfff)); seq++;
            srcq[src].push_back(f); shadow[src].push_back(f);
        end else begin
            f.kind = 2'b01; f.data = DW'((src << 12) | (seq & 12'hfff)); seq++;
            srcq[src].push_back(f); shadow[src].push_back(f);
            for (int b = 0; b < nbody; b++) begin
                f.kind = 2'b00; f.data = DW'((src << 12) | (seq & 12'hfff)); seq++;
                srcq[src].push_back(f); shadow[src].push_back(f);
            end
            f.kind = 2'b10; f.data = DW'((src << 12) | (seq & 12'hfff)); seq++;
            f.gap = 8'(tail_gap);
            srcq[src].push_back(f); shadow[src].push_back(f);
        end
    endtask

    // Driver: the next packet of src is expected next on the link
    task automatic expect_pkt(input int src);
        sflit_t f;
        exp_t e;
        do begin
            f = shadow[src].pop_front();
            e.src = 8'(src); e.kind = f.kind; e.data = f.data;
            expq.push_back(e);
        end while (!f.kind[1]);
    endtask

    // Source model: advance popped sources and present the next flit
    initial begin
        in_valid = '0; in_kind = '0; in_data = '0; out_ready = 1'b1;
        armed = '0; cyc = 0;
        for (int i = 0; i < NI; i++) wait_c[i] = 0;
        forever begin
            @(posedge clk);
            #1;
            for (int i = 0; i < NI; i++) begin
                if (pop_seen[i] && srcq[i].size() > 0) begin
                    void'(srcq[i].pop_front());
                    armed[i] = 1'b0;
                end
                if (srcq[i].size() > 0 && !armed[i]) begin
                    wait_c[i] = int'(srcq[i][0].gap);
                    armed[i] = 1'b1;
                end else if (wait_c[i] > 0) begin
                    wait_c[i]--;
                end
                in_valid[i] = (srcq[i].size() > 0) && armed[i] && (wait_c[i] == 0);
                in_kind[2*i +: 2]  = (srcq[i].size() > 0) ? srcq[i][0].kind : 2'b00;
                in_data[DW*i +: DW] = (srcq[i].size() > 0) ? srcq[i][0].data : '0;
            end
            out_ready = ready_mode ? ((cyc % 3) != 1) : 1'b1;
            cyc++;
        end
    end

    // Monitor: compare each crossing flit against the scoreboard
    initial begin
        pop_seen = '0;
        forever begin
            @(negedge clk);
            pop_seen = in_pop;
            if (rst_n) begin
                if (!out_ready)
                    check(!out_valid && in_pop == '0, "R6 no transfer without ready",
                          64'(out_valid), 64'd0);
                if (out_valid) begin
                    int s;
                    exp_t e;
                    s = -1;
                    for (int i = 0; i < NI; i++) if (in_pop[i]) s = i;
                    if (expq.size() == 0) begin
                        check(1'b0, "R4 unexpected flit", 64'(out_data), 64'd0);
                    end else begin
                        e = expq.pop_front();
                        check(out_data == e.data && out_kind == e.kind,
                              "R1 flit payload and kind", {out_kind, out_data},
                              {e.kind, e.data});
                        check(s == int'(e.src), "R5 R7 source order",
                              64'(s), 64'(e.src));
                        if (out_kind[0])
                            check(link_free == 1'b1, "R4 head only on free link",
                                  64'(link_free), 64'd1);
                        else
                            check(!link_free && link_owner[e.src[1:0]],
                                  "R2 owner carries body/tail", 64'(link_owner),
                                  64'(1 << e.src));
                    end
                end
            end
        end
    end

    task automatic drain_and_idle(input string tag);
        while (expq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        check(link_free == 1'b1 && link_owner == '0, tag,
              {link_free, 4'(link_owner)}, 64'h10);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        n_errs++; n_checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        n_checks = 0; n_errs = 0; seq = 0; ready_mode = 1'b0;
        rst_n = 1'b0;
        // R10: input 2 offers a one-flit packet while held in reset
        send_packet(2, 0, 1'b1, 0);
        repeat (3) @(negedge clk);
        check(!out_valid && in_pop == '0, "R10 quiet in reset",
              {out_valid, 4'(in_pop)}, 64'd0);
        check(link_free == 1'b1 && link_owner == '0, "R10 reset state",
              {link_free, 4'(link_owner)}, 64'h10);
        expect_pkt(2);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: the one-flit packet leaves the link free (pointer now 3)
        drain_and_idle("R9 one-flit leaves link free");

        // R5: inputs 1 and 2 contend from pointer 3: 1 wins, then 2
        send_packet(1, 1, 1'b0, 0);
        send_packet(2, 1, 1'b0, 0);
        expect_pkt(1); expect_pkt(2);
        drain_and_idle("R8 link free after tails");

        // R5: all four contend from pointer 3: order 3,0,1,2
        send_packet(0, 0, 1'b1, 0);
        send_packet(1, 0, 1'b0, 0);
        send_packet(2, 2, 1'b0, 0);
        send_packet(3, 0, 1'b1, 0);
        expect_pkt(3); expect_pkt(0); expect_pkt(1); expect_pkt(2);
        drain_and_idle("R8 R9 link free after mixed packets");

        // R6: back-pressure pattern, pointer 3: input 3 then input 0
        ready_mode = 1'b1;
        send_packet(0, 1, 1'b0, 0);
        send_packet(3, 0, 1'b0, 0);
        expect_pkt(3); expect_pkt(0);
        drain_and_idle("R6 R8 link free after back-pressure");
        ready_mode = 1'b0;

        // R11: input 1 stalls before its tail while input 2 waits, pointer 1
        send_packet(1, 1, 1'b0, 6);
        send_packet(2, 0, 1'b1, 0);
        expect_pkt(1); expect_pkt(2);
        while (expq.size() != 2) @(negedge clk);
        repeat (2) @(negedge clk);
        check(!link_free && link_owner == 4'b0010, "R11 stall keeps owner",
              {link_free, 4'(link_owner)}, 64'h02);
        check(!out_valid && in_pop == '0, "R4 waiting head held off",
              {out_valid, 4'(in_pop)}, 64'd0);
        drain_and_idle("R8 link free after stalled packet");

        finish_run();
    end

endmodule